// File: doc/BRIEF.md
# Host Bus Polarity and Request Front-End

This block sits between the processor side of a host port and the pins of an external host bus. It holds a 16-bit port control register and an 8-bit interrupt vector register. The processor writes both through a synchronous write strobe with a one-bit address. Three control bits set the polarity of the chip-select input, the request outputs and the acknowledge input. The remaining control fields enable the port, enable requests, choose between one combined request pin and two separate request pins, and select the multiplexed address/data bus mode.

The block turns the chip-select pin into an internal active-high select. It drives the request pins from the transmit-ready and receive-ready inputs. It also steers the host data bus. While acknowledge is active, the vector register goes onto the bus. During a selected read, the processor-side read data goes onto the bus. In every other case the bus output enable is low. Pin decoding is combinational from the registered control bits, so a control write changes pin behaviour from the clock edge that stores it.

Top module: `hbus_pol_frontend`

## Requirements
- R1: After reset the control and vector registers are zero. As a result, select is active while the chip-select pin is low, every request pin is high (inactive, active-low), and acknowledge is active while its pin is low.
- R2: When `cfg_wr_en` is high at a rising clock edge, `cfg_wdata` is stored. Address 0 stores all 16 bits into the control register. Address 1 stores bits 7:0 into the vector register. The new value affects the outputs only from that edge onward.
- R3: When the multiplexed bit (control bit 3) is 0, control bit 13 sets chip-select polarity. With bit 13 = 0, `sel_o` is high while `pin_sel` is low. With bit 13 = 1, `sel_o` is high while `pin_sel` is high.
- R4: When control bit 3 = 1, control bit 13 is ignored and `sel_o` is high exactly while `pin_sel` is low.
- R5: Requests can assert only when both the host enable bit (control bit 0) and the request enable bit (control bit 1) are 1. Otherwise all three request pins sit at the inactive level, which is the inverse of control bit 14.
- R6: In single-request mode (control bit 2 = 0), `req_comb_o` asserts when `tx_ready` or `rx_ready` is high. `req_tx_o` and `req_rx_o` stay inactive.
- R7: In double-request mode (control bit 2 = 1), `req_tx_o` follows `tx_ready` and `req_rx_o` follows `rx_ready`. `req_comb_o` stays inactive.
- R8: Control bit 14 sets request polarity: 0 means an asserted request drives the pin low, and 1 means it drives the pin high.
- R9: Control bit 15 sets acknowledge polarity: 0 means active while `pin_ack` is low, and 1 means active while it is high. While acknowledge is active, `hd_oe_o` = 1 and `hd_o` equals the vector register.
- R10: When acknowledge is inactive, `sel_o` is high and `host_rd` is high, `hd_oe_o` = 1 and `hd_o` equals `rd_data`. Acknowledge takes priority over a read.
- R11: In all other cases `hd_oe_o` = 0 and `hd_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Processor-side register write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 vector |
| cfg_wdata | input | 16 | Write data |
| pin_sel | input | 1 | Chip-select pin, polarity programmable |
| pin_ack | input | 1 | Acknowledge pin, polarity programmable |
| host_rd | input | 1 | Host read strobe, active high |
| tx_ready | input | 1 | Internal transmit-ready status |
| rx_ready | input | 1 | Internal receive-ready status |
| rd_data | input | 8 | Processor-side read data for host reads |
| sel_o | output | 1 | Internal select, active high |
| req_comb_o | output | 1 | Combined request pin |
| req_tx_o | output | 1 | Transmit request pin |
| req_rx_o | output | 1 | Receive request pin |
| hd_o | output | 8 | Host data bus output value |
| hd_oe_o | output | 1 | Host data bus output enable |

## Verification
The assertions assume the pins and status inputs are settled at each rising edge. They also assume `cfg_addr` is meaningful only while `cfg_wr_en` is high. The stimulus drives every input on the falling edge, and it raises the write strobe for exactly one rising edge per register write. Each scenario sets the control word it needs before it moves the pins. This keeps every pin combination the checks look at inside one stable control setting.

// File: rtl/hbfe_pkg.sv
package hbfe_pkg;
    localparam int CTRL_W   = 16;
    localparam int VEC_W    = 8;
    localparam int HEN_BIT  = 0;
    localparam int REN_BIT  = 1;
    localparam int DREQ_BIT = 2;
    localparam int MUX_BIT  = 3;
    localparam int CSP_BIT  = 13;
    localparam int RQP_BIT  = 14;
    localparam int AKP_BIT  = 15;

    typedef struct packed {
        logic host_en;
        logic req_en;
        logic dual_req;
        logic mux_bus;
        logic cs_pol;
        logic req_pol;
        logic ack_pol;
    } ctrl_fields_t;

    function automatic ctrl_fields_t unpack_ctrl(input logic [CTRL_W-1:0] r);
        ctrl_fields_t f;
        f.host_en  = r[HEN_BIT];
        f.req_en   = r[REN_BIT];
        f.dual_req = r[DREQ_BIT];
        f.mux_bus  = r[MUX_BIT];
        f.cs_pol   = r[CSP_BIT];
        f.req_pol  = r[RQP_BIT];
        f.ack_pol  = r[AKP_BIT];
        return f;
    endfunction
endpackage

// File: rtl/hbfe_regs.sv
module hbfe_regs
    import hbfe_pkg::*;
#(
    parameter int CW = CTRL_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] ctrl_q,
    output logic [VW-1:0] vec_q
);
    typedef struct packed {
        logic [CW-1:0] ctrl;
        logic [VW-1:0] vec;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr) st_d.vec  = wr_data[VW-1:0];
            else         st_d.ctrl = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;
    assign vec_q  = st_q.vec;
endmodule

// File: rtl/hbfe_pin_decode.sv
module hbfe_pin_decode
    import hbfe_pkg::*;
(
    input  ctrl_fields_t cf,
    input  logic         pin_sel,
    input  logic         pin_ack,
    output logic         sel,
    output logic         ack_act
);
    always_comb begin
        // multiplexed bus mode forces the low-active reading of chip select
        if (cf.mux_bus) sel = ~pin_sel;
        else            sel = cf.cs_pol ? pin_sel : ~pin_sel;
        ack_act = cf.ack_pol ? pin_ack : ~pin_ack;
    end
endmodule

// File: rtl/hbfe_req_drive.sv
module hbfe_req_drive
    import hbfe_pkg::*;
#(
    parameter int LANES = 3
) (
    input  ctrl_fields_t     cf,
    input  logic             tx_rdy,
    input  logic             rx_rdy,
    output logic [LANES-1:0] req_pins
);
    logic             enabled;
    logic [LANES-1:0] lane_act;

    always_comb begin
        enabled  = cf.host_en & cf.req_en;
        lane_act = '0;
        // lane 0 combined, lane 1 transmit, lane 2 receive
        lane_act[0] = enabled & ~cf.dual_req & (tx_rdy | rx_rdy);
        lane_act[1] = enabled &  cf.dual_req & tx_rdy;
        lane_act[2] = enabled &  cf.dual_req & rx_rdy;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign req_pins[i] = lane_act[i] ? cf.req_pol : ~cf.req_pol;
    end
endmodule

// File: rtl/hbfe_bus_mux.sv
module hbfe_bus_mux #(
    parameter int DW = 8
) (
    input  logic          ack_act,
    input  logic          sel,
    input  logic          host_rd,
    input  logic [DW-1:0] vec,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] hd,
    output logic          hd_oe
);
    always_comb begin
        hd    = '0;
        hd_oe = 1'b0;
        if (ack_act) begin
            hd    = vec;
            hd_oe = 1'b1;
        end else if (sel && host_rd) begin
            hd    = rd_data;
            hd_oe = 1'b1;
        end
    end
endmodule

// File: rtl/hbus_pol_frontend.sv
module hbus_pol_frontend
    import hbfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_addr,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              pin_sel,
    input  logic              pin_ack,
    input  logic              host_rd,
    input  logic              tx_ready,
    input  logic              rx_ready,
    input  logic [VEC_W-1:0]  rd_data,
    output logic              sel_o,
    output logic              req_comb_o,
    output logic              req_tx_o,
    output logic              req_rx_o,
    output logic [VEC_W-1:0]  hd_o,
    output logic              hd_oe_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [VEC_W-1:0]  vec_q;
    ctrl_fields_t      cf;
    logic              ack_act;
    logic [2:0]        req_pins;

    hbfe_regs #(.CW(CTRL_W), .VW(VEC_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .ctrl_q(ctrl_q), .vec_q(vec_q)
    );

    assign cf = unpack_ctrl(ctrl_q);

    hbfe_pin_decode dec_i (
        .cf(cf), .pin_sel(pin_sel), .pin_ack(pin_ack),
        .sel(sel_o), .ack_act(ack_act)
    );

    hbfe_req_drive #(.LANES(3)) req_i (
        .cf(cf), .tx_rdy(tx_ready), .rx_rdy(rx_ready), .req_pins(req_pins)
    );

    assign req_comb_o = req_pins[0];
    assign req_tx_o   = req_pins[1];
    assign req_rx_o   = req_pins[2];

    hbfe_bus_mux #(.DW(VEC_W)) mux_i (
        .ack_act(ack_act), .sel(sel_o), .host_rd(host_rd),
        .vec(vec_q), .rd_data(rd_data), .hd(hd_o), .hd_oe(hd_oe_o)
    );
endmodule

// File: rtl/hbfe_checker.sv
module hbfe_checker
    import hbfe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic              cfg_addr,
    input logic [CTRL_W-1:0] cfg_wdata,
    input logic              pin_sel,
    input logic              pin_ack,
    input logic              sel_o,
    input logic              req_comb_o,
    input logic              req_tx_o,
    input logic              req_rx_o,
    input logic [VEC_W-1:0]  hd_o,
    input logic              hd_oe_o,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [VEC_W-1:0]  vec_q
);
    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_addr) |=> ctrl_q == $past(cfg_wdata));

    assert_vec_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr) |=> vec_q == $past(cfg_wdata[VEC_W-1:0]));

    assert_mux_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[MUX_BIT] |-> (sel_o == !pin_sel));

    assert_req_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q[HEN_BIT] && ctrl_q[REN_BIT]) |->
        (req_comb_o == !ctrl_q[RQP_BIT] && req_tx_o == !ctrl_q[RQP_BIT]
         && req_rx_o == !ctrl_q[RQP_BIT]));

    assert_single_split_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[DREQ_BIT] |->
        (req_tx_o == !ctrl_q[RQP_BIT] && req_rx_o == !ctrl_q[RQP_BIT]));

    assert_dual_comb_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[DREQ_BIT] |-> (req_comb_o == !ctrl_q[RQP_BIT]));

    assert_ack_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ack == ctrl_q[AKP_BIT]) |-> (hd_oe_o && hd_o == vec_q));

    assert_bus_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hd_oe_o |-> (hd_o == '0));
endmodule

bind hbus_pol_frontend hbfe_checker chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_sel(pin_sel), .pin_ack(pin_ack),
    .sel_o(sel_o), .req_comb_o(req_comb_o), .req_tx_o(req_tx_o),
    .req_rx_o(req_rx_o), .hd_o(hd_o), .hd_oe_o(hd_oe_o),
    .ctrl_q(ctrl_q), .vec_q(vec_q)
);

// File: tb/hbus_pol_frontend_tb_top.sv
module hbus_pol_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        pin_sel = 1'b1;
    logic        pin_ack = 1'b1;
    logic        host_rd = 1'b0;
    logic        tx_ready = 1'b0;
    logic        rx_ready = 1'b0;
    logic [7:0]  rd_data = 8'hA5;
    logic        sel_o, req_comb_o, req_tx_o, req_rx_o, hd_oe_o;
    logic [7:0]  hd_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    hbus_pol_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pin_sel(pin_sel), .pin_ack(pin_ack),
        .host_rd(host_rd), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .rd_data(rd_data), .sel_o(sel_o), .req_comb_o(req_comb_o),
        .req_tx_o(req_tx_o), .req_rx_o(req_rx_o), .hd_o(hd_o), .hd_oe_o(hd_oe_o)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic addr, input logic [15:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset_R1();
        pin_sel = 1'b0; pin_ack = 1'b1; tx_ready = 1'b1; settle();
        check("R1", "sel low pin", {15'd0, sel_o}, 16'd1);
        check("R1", "requests idle", {13'd0, req_comb_o, req_tx_o, req_rx_o}, 16'h7);
        check("R1", "bus off", {7'd0, hd_oe_o, hd_o}, 16'h0000);
        pin_ack = 1'b0; settle();
        check("R1", "ack low drives zero vector", {7'd0, hd_oe_o, hd_o}, 16'h0100);
        pin_ack = 1'b1; tx_ready = 1'b0;
    endtask

    task automatic t_cs_pol_R3();
        pin_sel = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 1'b0; cfg_wdata = 16'h2000; settle();
        check("R2", "no effect before edge", {15'd0, sel_o}, 16'd0);
        @(negedge clk);
        cfg_wr_en = 1'b0; settle();
        check("R3", "high pol, pin high", {15'd0, sel_o}, 16'd1);
        pin_sel = 1'b0; settle();
        check("R3", "high pol, pin low", {15'd0, sel_o}, 16'd0);
    endtask

    task automatic t_mux_R4();
        write_reg(1'b0, 16'h2008);
        pin_sel = 1'b1; settle();
        check("R4", "mux ignores pol, pin high", {15'd0, sel_o}, 16'd0);
        pin_sel = 1'b0; settle();
        check("R4", "mux ignores pol, pin low", {15'd0, sel_o}, 16'd1);
    endtask

    task automatic t_enable_R5();
        tx_ready = 1'b1; rx_ready = 1'b1;
        write_reg(1'b0, 16'h0002); settle();
        check("R5", "no host enable", {13'd0, req_comb_o, req_tx_o, req_rx_o}, 16'h7);
        write_reg(1'b0, 16'h0001); settle();
        check("R5", "no request enable", {13'd0, req_comb_o, req_tx_o, req_rx_o}, 16'h7);
        write_reg(1'b0, 16'h0003); settle();
        check("R5", "both enables", {15'd0, req_comb_o}, 16'd0);
        tx_ready = 1'b0; rx_ready = 1'b0;
    endtask

    task automatic t_single_R6();
        write_reg(1'b0, 16'h0003);
        settle();
        check("R6", "none ready", {15'd0, req_comb_o}, 16'd1);
        rx_ready = 1'b1; settle();
        check("R6", "rx ready only", {13'd0, req_comb_o, req_tx_o, req_rx_o}, 16'h3);
        rx_ready = 1'b0; tx_ready = 1'b1; settle();
        check("R6", "tx ready only", {13'd0, req_comb_o, req_tx_o, req_rx_o}, 16'h3);
        tx_ready = 1'b0;
    endtask

    task automatic t_dual_R7();
        write_reg(1'b0, 16'h0007);
        tx_ready = 1'b1; rx_ready = 1'b0; settle();
        check("R7", "tx only", {13'd0, req_comb_o, req_tx_o, req_rx_o}, 16'h5);
        tx_ready = 1'b0; rx_ready = 1'b1; settle();
        check("R7", "rx only", {13'd0, req_comb_o, req_tx_o, req_rx_o}, 16'h6);
        rx_ready = 1'b0;
    endtask

    task automatic t_req_pol_R8();
        write_reg(1'b0, 16'h4007);
        tx_ready = 1'b1; rx_ready = 1'b0; settle();
        check("R8", "active high dual", {13'd0, req_comb_o, req_tx_o, req_rx_o}, 16'h2);
        write_reg(1'b0, 16'h4003); settle();
        check("R8", "active high single", {13'd0, req_comb_o, req_tx_o, req_rx_o}, 16'h4);
        write_reg(1'b0, 16'h4000); settle();
        check("R8", "disabled high pol idle low", {13'd0, req_comb_o, req_tx_o, req_rx_o}, 16'h0);
        tx_ready = 1'b0;
    endtask

    task automatic t_ack_R9();
        write_reg(1'b1, 16'hFF3C);
        write_reg(1'b0, 16'h8000);
        pin_ack = 1'b1; settle();
        check("R9", "high pol ack high", {7'd0, hd_oe_o, hd_o}, 16'h013C);
        pin_ack = 1'b0; settle();
        check("R9", "high pol ack low", {7'd0, hd_oe_o, hd_o}, 16'h0000);
    endtask

    task automatic t_read_R10();
        write_reg(1'b0, 16'h0000);
        pin_ack = 1'b1; pin_sel = 1'b0; host_rd = 1'b1; settle();
        check("R10", "selected read", {7'd0, hd_oe_o, hd_o}, 16'h01A5);
        pin_ack = 1'b0; settle();
        check("R10", "ack over read", {7'd0, hd_oe_o, hd_o}, 16'h013C);
        pin_ack = 1'b1; pin_sel = 1'b1; settle();
        check("R11", "read without select", {7'd0, hd_oe_o, hd_o}, 16'h0000);
        pin_sel = 1'b0; host_rd = 1'b0; settle();
        check("R11", "select without read", {7'd0, hd_oe_o, hd_o}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_R1();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_cs_pol_R3();
        t_mux_R4();
        t_enable_R5();
        t_single_R6();
        t_dual_R7();
        t_req_pol_R8();
        t_ack_R9();
        t_read_R10();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule